// File: doc/BRIEF.md
# Push-Button Press Pulse Conditioner

This block takes the raw level of a mechanical push button, which is asynchronous to the system clock and bounces when pressed and released. It produces a pulse one clock cycle long for each clean press. The button level is first brought into the clock domain through a two-register synchroniser. Each synchronised sample then enters a 16-bit shift history. In the default pattern mode, a press is recognised only when the history shows exactly two low samples followed by fourteen high samples. This filters out contact bounce without a separate debounce timer.

A parameter selects a lockout mode instead. In this mode the pulse fires on the first synchronised low-to-high change, and all further rises are ignored for a fixed number of cycles. The pulse comes much sooner, but a single-cycle glitch is taken as a press. In both modes, reset clears all state. Any match or rise seen while the history still holds reset filler (the first 18 cycles after reset) is discarded, so a button held down through reset gives no pulse.

Top module: `key_press_conditioner`

## Requirements
- R1: The raw button passes through two clock registers before any other logic. If the raw level is first captured high at clock edge E1 after a long low period, the pattern-mode pulse is high only in the cycle after edge E17.
- R2: Every clock the newest synchronised sample enters history bit 0 and older samples move one bit toward bit 15.
- R3: Every pulse lasts exactly one clock cycle.
- R4: In pattern mode a pulse is issued only after the history equals 16'b0011111111111111 (bit 15 first). A high run of 13 samples gives no pulse; a high run of 14 samples preceded by at least two lows gives one pulse.
- R5: In pattern mode, bounce (short high and low runs) followed by a steady high level preceded by at least two lows gives exactly one pulse.
- R6: Holding the button high indefinitely after its pulse, or releasing it, produces no further pulse.
- R7: While reset (active low) is asserted the pulse output is low, and all internal state is cleared.
- R8: A match or rise whose deciding sample arrives within the first 18 clock edges after reset release is discarded, so a button held high through reset gives no pulse in either mode.
- R9: In lockout mode, a raw rise first captured at edge E1 gives a pulse in the cycle after edge E3.
- R10: In lockout mode, rises evaluated within 16 cycles after a pulse is issued are ignored, and a rise after that window is accepted again.
- R11: In lockout mode, a raw high lasting a single clock cycle is accepted as a press, while pattern mode gives no pulse for it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| rawKey | input | 1 | Raw, asynchronous, bouncing button level |
| pressPulse | output | 1 | One-cycle pulse per recognised press |

## Verification
The assertions check the following on every cycle: the synchroniser and history shift order, the one-cycle pulse width, that a pattern-mode pulse always follows the exact signature, the post-reset quiet window, and the minimum spacing between lockout pulses. Only the bench scenarios can show other behaviours. These include the exact latency from a press to its pulse and that bounce yields a single pulse. They also include that presses of 13 and 14 samples fall on opposite sides of the threshold, that a held or released button stays silent, and that a lone glitch passes in lockout mode but not in pattern mode.

// File: rtl/kpc_pkg.sv
package kpc_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic emit;        // load a one into the pulse register
  } kpcStrobe_t;

  // Observations from datapath to control
  typedef struct packed {
    logic patternHit;  // history equals the stable-rise signature
    logic riseHit;     // synchronised level went low to high
  } kpcStatus_t;

endpackage

// File: rtl/kpc_datapath.sv
module kpc_datapath
  import kpc_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int HIST_W      = 16,
  parameter int LOW_RUN     = 2
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   rawKey,
  input  kpcStrobe_t             strobe,
  output kpcStatus_t             status,
  output logic                   pressPulse,
  output logic [SYNC_STAGES-1:0] syncQ,
  output logic [HIST_W-1:0]      histQ
);

  localparam int HIGH_RUN = HIST_W - LOW_RUN;
  localparam logic [HIST_W-1:0] SIGNATURE = {{LOW_RUN{1'b0}}, {HIGH_RUN{1'b1}}};

  logic syncTail;

  // Synchroniser chain
  generate
    for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) syncQ[0] <= 1'b0;
          else       syncQ[0] <= rawKey;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) syncQ[i] <= 1'b0;
          else       syncQ[i] <= syncQ[i-1];
        end
      end
    end
  endgenerate

  assign syncTail = syncQ[SYNC_STAGES-1];

  // Sample history, newest at bit 0
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) histQ <= '0;
    else       histQ <= {histQ[HIST_W-2:0], syncTail};
  end

  always_comb begin
    status.patternHit = (histQ == SIGNATURE);
    status.riseHit    = syncTail & ~histQ[0];
  end

  // Registered output pulse
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pressPulse <= 1'b0;
    else       pressPulse <= strobe.emit;
  end

endmodule

// File: rtl/kpc_control.sv
module kpc_control
  import kpc_pkg::*;
#(
  parameter bit USE_LOCKOUT = 1'b0,
  parameter int LOCK_CYCLES = 16,
  parameter int WARM        = 18
) (
  input  logic       clk,
  input  logic       rstN,
  input  kpcStatus_t status,
  output kpcStrobe_t strobe
);

  localparam int WARM_W = $clog2(WARM + 1);
  localparam int LOCK_W = $clog2(LOCK_CYCLES + 1);

  logic [WARM_W-1:0] warmCnt;
  logic              warmDone;
  logic              candidate;
  logic              lockIdle;

  // Post-reset warm-up: history still holds reset filler
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          warmCnt <= '0;
    else if (!warmDone) warmCnt <= warmCnt + 1'b1;
  end

  assign warmDone  = (warmCnt == WARM_W'(WARM));
  assign candidate = USE_LOCKOUT ? status.riseHit : status.patternHit;

  generate
    if (USE_LOCKOUT) begin : g_lock
      logic [LOCK_W-1:0] lockCnt;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                 lockCnt <= '0;
        else if (strobe.emit)      lockCnt <= LOCK_W'(LOCK_CYCLES);
        else if (lockCnt != '0)    lockCnt <= lockCnt - 1'b1;
      end
      assign lockIdle = (lockCnt == '0);
    end else begin : g_pattern
      assign lockIdle = 1'b1;
    end
  endgenerate

  always_comb strobe.emit = warmDone & lockIdle & candidate;

endmodule

// File: rtl/key_press_conditioner.sv
module key_press_conditioner
  import kpc_pkg::*;
#(
  parameter bit USE_LOCKOUT = 1'b0,
  parameter int LOCK_CYCLES = 16,
  parameter int SYNC_STAGES = 2,
  parameter int HIST_W      = 16,
  parameter int LOW_RUN     = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic rawKey,
  output logic pressPulse
);

  localparam int WARM = HIST_W + SYNC_STAGES;

  kpcStrobe_t             strobe;
  kpcStatus_t             status;
  logic [SYNC_STAGES-1:0] syncQ;
  logic [HIST_W-1:0]      histQ;

  kpc_datapath #(
    .SYNC_STAGES(SYNC_STAGES),
    .HIST_W     (HIST_W),
    .LOW_RUN    (LOW_RUN)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .rawKey    (rawKey),
    .strobe    (strobe),
    .status    (status),
    .pressPulse(pressPulse),
    .syncQ     (syncQ),
    .histQ     (histQ)
  );

  kpc_control #(
    .USE_LOCKOUT(USE_LOCKOUT),
    .LOCK_CYCLES(LOCK_CYCLES),
    .WARM       (WARM)
  ) u_ctl (
    .clk   (clk),
    .rstN  (rstN),
    .status(status),
    .strobe(strobe)
  );

endmodule

// File: rtl/kpc_checker.sv
module kpc_checker #(
  parameter bit USE_LOCKOUT = 1'b0,
  parameter int LOCK_CYCLES = 16,
  parameter int SYNC_STAGES = 2,
  parameter int HIST_W      = 16,
  parameter int LOW_RUN     = 2
) (
  input logic                   clk,
  input logic                   rstN,
  input logic                   rawKey,
  input logic                   pressPulse,
  input logic [SYNC_STAGES-1:0] syncQ,
  input logic [HIST_W-1:0]      histQ
);

  localparam int WARM   = HIST_W + SYNC_STAGES;
  localparam int AGE_W  = $clog2(WARM + 2);
  localparam int GAP_W  = $clog2(LOCK_CYCLES + 1);
  localparam logic [HIST_W-1:0] SIGNATURE =
    {{LOW_RUN{1'b0}}, {(HIST_W-LOW_RUN){1'b1}}};

  logic [AGE_W-1:0] sinceReset;
  logic [GAP_W-1:0] sinceFire;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                              sinceReset <= '0;
    else if (sinceReset != AGE_W'(WARM + 1)) sinceReset <= sinceReset + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                   sinceFire <= GAP_W'(LOCK_CYCLES);
    else if (pressPulse)                         sinceFire <= '0;
    else if (sinceFire != GAP_W'(LOCK_CYCLES))   sinceFire <= sinceFire + 1'b1;
  end

  // R1: first synchroniser stage captures the raw level
  a_r1_sync_capture: assert property (@(posedge clk) disable iff (!rstN)
    (sinceReset != '0) |-> (syncQ[0] == $past(rawKey)));

  // R2: history bit 0 takes the synchroniser output of the previous cycle
  a_r2_hist_shift: assert property (@(posedge clk) disable iff (!rstN)
    (sinceReset != '0) |-> (histQ[0] == $past(syncQ[SYNC_STAGES-1])));

  // R3: pulse is one cycle wide
  a_r3_one_cycle: assert property (@(posedge clk) disable iff (!rstN)
    pressPulse |=> !pressPulse);

  // R4: pattern-mode pulse follows the exact signature
  a_r4_signature: assert property (@(posedge clk) disable iff (!rstN)
    (!USE_LOCKOUT && pressPulse) |-> ($past(histQ) == SIGNATURE));

  // R8: nothing fires during the post-reset window
  a_r8_warmup: assert property (@(posedge clk) disable iff (!rstN)
    pressPulse |-> (sinceReset > AGE_W'(WARM)));

  // R10: lockout pulses are spaced by the lockout window
  a_r10_lock_gap: assert property (@(posedge clk) disable iff (!rstN)
    (USE_LOCKOUT && pressPulse) |-> (sinceFire == GAP_W'(LOCK_CYCLES)));

endmodule

bind key_press_conditioner kpc_checker #(
  .USE_LOCKOUT(USE_LOCKOUT),
  .LOCK_CYCLES(LOCK_CYCLES),
  .SYNC_STAGES(SYNC_STAGES),
  .HIST_W     (HIST_W),
  .LOW_RUN    (LOW_RUN)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .rawKey    (rawKey),
  .pressPulse(pressPulse),
  .syncQ     (syncQ),
  .histQ     (histQ)
);

// File: tb/tb_key_press_conditioner.sv
`timescale 1ns/1ps
module tb_key_press_conditioner;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rawKey = 1'b0;
  logic patPulse;
  logic lockPulse;

  int checkCount = 0;
  int failCount  = 0;
  bit finished   = 1'b0;

  int pFirst, pCount, lFirst, lCount, sampleIdx;

  always #2.5 clk = ~clk;

  key_press_conditioner #(.USE_LOCKOUT(1'b0)) dut (
    .clk(clk), .rstN(rstN), .rawKey(rawKey), .pressPulse(patPulse));

  key_press_conditioner #(.USE_LOCKOUT(1'b1), .LOCK_CYCLES(16)) dutLock (
    .clk(clk), .rstN(rstN), .rawKey(rawKey), .pressPulse(lockPulse));

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checkCount++;
    if (!ok) begin
      failCount++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic clearObs();
    pFirst = 0; pCount = 0; lFirst = 0; lCount = 0; sampleIdx = 0;
  endtask

  // Set the raw level at the current falling edge, then sample n falling edges
  task automatic drive(input bit level, input int n);
    rawKey = level;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      sampleIdx++;
      if (patPulse) begin
        pCount++;
        if (pFirst == 0) pFirst = sampleIdx;
      end
      if (lockPulse) begin
        lCount++;
        if (lFirst == 0) lFirst = sampleIdx;
      end
    end
  endtask

  task automatic doReset(input bit level);
    rawKey = level;
    @(negedge clk);
    rstN = 1'b0;
    #1;
    check(patPulse == 1'b0 && lockPulse == 1'b0, "R7 pulse low in reset",
          patPulse + lockPulse, 0);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic testResetState();
    doReset(1'b0);
    clearObs();
    drive(1'b0, 30);
    check(pCount == 0 && lCount == 0, "R8 idle after reset", pCount + lCount, 0);
  endtask

  task automatic testCleanPress();
    clearObs();
    drive(1'b1, 40);
    check(pFirst == 17, "R1 R2 pattern latency", pFirst, 17);
    check(pCount == 1, "R3 pattern single pulse", pCount, 1);
    check(lFirst == 3, "R9 lockout latency", lFirst, 3);
    check(lCount == 1, "R3 lockout single pulse", lCount, 1);
    clearObs();
    drive(1'b1, 50);
    check(pCount == 0 && lCount == 0, "R6 held high", pCount + lCount, 0);
    clearObs();
    drive(1'b0, 40);
    check(pCount == 0 && lCount == 0, "R6 released", pCount + lCount, 0);
  endtask

  task automatic testShortPress();
    clearObs();
    drive(1'b1, 13);
    drive(1'b0, 40);
    check(pCount == 0, "R4 thirteen highs", pCount, 0);
    check(lCount == 1, "R9 lockout short press", lCount, 1);
    clearObs();
    drive(1'b1, 14);
    drive(1'b0, 40);
    check(pCount == 1, "R4 fourteen highs", pCount, 1);
  endtask

  task automatic testBounce();
    clearObs();
    drive(1'b1, 1);
    drive(1'b0, 1);
    drive(1'b1, 2);
    drive(1'b0, 2);
    drive(1'b1, 40);
    check(pCount == 1, "R5 bounce pattern", pCount, 1);
    check(lCount == 1, "R10 bounce inside lockout", lCount, 1);
    drive(1'b0, 40);
  endtask

  task automatic testGlitches();
    clearObs();
    drive(1'b1, 1);
    drive(1'b0, 24);
    drive(1'b1, 1);
    drive(1'b0, 30);
    check(lCount == 2, "R11 R10 glitches apart", lCount, 2);
    check(pCount == 0, "R11 pattern rejects glitch", pCount, 0);
    clearObs();
    drive(1'b1, 1);
    drive(1'b0, 8);
    drive(1'b1, 1);
    drive(1'b0, 30);
    check(lCount == 1, "R10 glitches close", lCount, 1);
  endtask

  task automatic testHoldThroughReset();
    clearObs();
    drive(1'b1, 5);
    doReset(1'b1);
    clearObs();
    drive(1'b1, 60);
    check(pCount == 0, "R8 held through reset pattern", pCount, 0);
    check(lCount == 0, "R8 held through reset lockout", lCount, 0);
    drive(1'b0, 30);
    clearObs();
    drive(1'b1, 30);
    check(pCount == 1 && lCount == 1, "R7 press after reset", pCount + lCount, 2);
  endtask

  initial begin
    clearObs();
    testResetState();
    testCleanPress();
    testShortPress();
    testBounce();
    testGlitches();
    testHoldThroughReset();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checkCount++;
      failCount++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
      $finish;
    end
  end

endmodule